// File: doc/BRIEF.md
# Strobe-framed serial I/Q deserializer

This block takes one serial data line and a companion strobe, both sampled on the rising edge of the incoming data clock, and rebuilds parallel words from them. Each word is either a pair of complex samples (an I word and a Q word) or a single symbol. The strobe tells the block where a frame begins. It can be a single-cycle pulse on the first bit, or a level that is high while the I half is on the line and low while the Q half is. Frame lengths are 32 bits for an I/Q pair, 16 bits for a wide symbol, and 8 bits for both the byte symbol and the padded 2-bit symbol.

Static configuration inputs choose four things:
- the strobe style;
- whether I or Q travels first;
- whether each word arrives MSB-first or LSB-first;
- the data format.

When the last bit of a frame has been sampled, the block loads the assembled words onto its outputs and raises a one-cycle valid. For 2-bit symbols it throws away the six padding bits. If a new frame start appears before the current frame is complete, the block reports a framing error, drops the partial word and re-aligns on the new start. The data clock is also passed back out as a reference clock for the sender.

Top module: `iq_deser`

## Requirements
- R1: While reset is asserted and after it is released, out_valid and frame_err are low and i_word and q_word are zero until the first frame completes.
- R2: With cfg_level_strobe=0 (pulse style), a cycle with ser_strobe high starts a frame, and the bit sampled in that same cycle is bit 0 of the frame.
- R3: With cfg_level_strobe=1 (level style), a frame starts only on a cycle where ser_strobe is high and was low in the previous cycle. A strobe held high does not start another frame.
- R4: With cfg_fmt=0 (I/Q pair, 32-bit frame), the first 16 bits form the I word and the last 16 form the Q word. When cfg_q_first=1 the two halves are swapped: the first 16 bits form the Q word.
- R5: With cfg_lsb_first=0, the first bit of each word lands in that word's most significant position. With cfg_lsb_first=1, it lands in bit 0.
- R6: With cfg_fmt=3 (wide symbol), a 16-bit frame is placed on i_word, q_word reads zero, and cfg_q_first has no effect.
- R7: With cfg_fmt=2 (byte symbol), an 8-bit frame is placed on i_word[7:0], and i_word[15:8] and q_word read zero.
- R8: With cfg_fmt=1 (2-bit symbol), an 8-bit frame is received and only the two data bits are kept on i_word[1:0]. These are the last two bits when MSB-first and the first two when LSB-first. The six padding bits are dropped, and all other output bits read zero.
- R9: out_valid goes high for exactly one cycle, in the cycle after the clock edge that sampled the final bit of a frame. i_word and q_word hold their values until the next valid.
- R10: A frame start seen while a frame is still incomplete raises frame_err for one cycle, in the cycle after that start. The partial frame produces no valid, and the start bit becomes bit 0 of a new frame.
- R11: In pulse style, a strobe that is still high on the second cycle of a frame is flagged as a framing error and re-aligns the frame to that second cycle.
- R12: Bits sampled while no frame is in progress and no start is seen are ignored. They produce no valid, and the outputs do not change.
- R13: ref_clk_out follows the data clock input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Incoming data clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_level_strobe | input | 1 | 0 selects the pulse strobe, 1 selects the level strobe |
| cfg_q_first | input | 1 | 1 means the Q half travels first in I/Q frames |
| cfg_lsb_first | input | 1 | 1 means each word arrives LSB-first |
| cfg_fmt | input | 2 | 0 = I/Q pair, 1 = 2-bit symbol, 2 = 8-bit symbol, 3 = 16-bit symbol |
| ser_strobe | input | 1 | Frame strobe |
| ser_data | input | 1 | Serial data bit |
| ref_clk_out | output | 1 | Reference clock returned to the sender |
| i_word | output | IQ_W (16) | Assembled I word, or the symbol |
| q_word | output | IQ_W (16) | Assembled Q word; zero for symbols |
| out_valid | output | 1 | One-cycle pulse when a frame completes |
| frame_err | output | 1 | One-cycle pulse on a premature frame start |

## Verification
The bench builds the block with its default widths: 16-bit I/Q words, 8-bit byte frames and 2-bit narrow symbols. At these sizes all 32 combinations of strobe style, half order, bit order and format can be swept, with several arithmetically derived words per combination, sent both back-to-back and with idle gaps. Because the 2-bit symbols are sent with non-zero padding, any padding that leaks into the output shows up. Directed sequences then cover the misalignment cases: a pulse restarting mid-frame, a pulse held for two cycles, and a level rising again before the frame is complete. They also cover a level held high through and past a whole frame, and idle bits between frames.

// File: rtl/iq_deser.sv
module iq_deser #(
  parameter int IQ_W     = 16,
  parameter int BYTE_W   = 8,
  parameter int NARROW_W = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cfg_level_strobe,
  input  logic            cfg_q_first,
  input  logic            cfg_lsb_first,
  input  logic [1:0]      cfg_fmt,
  input  logic            ser_strobe,
  input  logic            ser_data,
  output logic            ref_clk_out,
  output logic [IQ_W-1:0] i_word,
  output logic [IQ_W-1:0] q_word,
  output logic            out_valid,
  output logic            frame_err
);

  localparam logic [1:0] FMT_IQ    = 2'd0;
  localparam logic [1:0] FMT_SYM2  = 2'd1;
  localparam logic [1:0] FMT_SYM8  = 2'd2;
  localparam logic [1:0] FMT_SYM16 = 2'd3;
  localparam int FULL_LEN = 2 * IQ_W;
  localparam int CW       = $clog2(FULL_LEN + 1);
  localparam int PW       = $clog2(IQ_W);
  localparam logic [CW-1:0] LEN_FULL = CW'(FULL_LEN);
  localparam logic [CW-1:0] LEN_HALF = CW'(IQ_W);
  localparam logic [CW-1:0] LEN_BYTE = CW'(BYTE_W);
  localparam logic [IQ_W-1:0] MASK_BYTE   = {{(IQ_W-BYTE_W){1'b0}}, {BYTE_W{1'b1}}};
  localparam logic [IQ_W-1:0] MASK_NARROW = {{(IQ_W-NARROW_W){1'b0}}, {NARROW_W{1'b1}}};

  logic            strobe_d, busy;
  logic [CW-1:0]   cnt, flen, span, idx, j;
  logic [PW-1:0]   pos;
  logic            start, take, last, second;
  logic [IQ_W-1:0] hw0, hw1, hw0_n, hw1_n, i_n, q_n;

  assign ref_clk_out = clk;
  assign start  = cfg_level_strobe ? (ser_strobe & ~strobe_d) : ser_strobe;
  assign take   = start | busy;
  assign idx    = start ? '0 : cnt;
  assign last   = take && (idx == flen - 1'b1);
  assign second = (cfg_fmt == FMT_IQ) && (idx >= LEN_HALF);
  assign j      = second ? idx - LEN_HALF : idx;
  assign pos    = cfg_lsb_first ? j[PW-1:0] : PW'(span - 1'b1 - j);

  always_comb begin
    case (cfg_fmt)
      FMT_IQ:    begin flen = LEN_FULL; span = LEN_HALF; end
      FMT_SYM16: begin flen = LEN_HALF; span = LEN_HALF; end
      default:   begin flen = LEN_BYTE; span = LEN_BYTE; end
    endcase
  end

  always_comb begin
    hw0_n = start ? '0 : hw0;
    hw1_n = start ? '0 : hw1;
    if (take) begin
      if (second) hw1_n[pos] = ser_data;
      else        hw0_n[pos] = ser_data;
    end
  end

  always_comb begin
    q_n = '0;
    case (cfg_fmt)
      FMT_IQ: begin
        i_n = cfg_q_first ? hw1_n : hw0_n;
        q_n = cfg_q_first ? hw0_n : hw1_n;
      end
      FMT_SYM16: i_n = hw0_n;
      FMT_SYM8:  i_n = hw0_n & MASK_BYTE;
      default:   i_n = hw0_n & MASK_NARROW;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_d  <= 1'b0;
      busy      <= 1'b0;
      cnt       <= '0;
      hw0       <= '0;
      hw1       <= '0;
      i_word    <= '0;
      q_word    <= '0;
      out_valid <= 1'b0;
      frame_err <= 1'b0;
    end else begin
      strobe_d  <= ser_strobe;
      out_valid <= last;
      frame_err <= start && busy;
      hw0       <= hw0_n;
      hw1       <= hw1_n;
      if (last) begin
        busy   <= 1'b0;
        cnt    <= '0;
        i_word <= i_n;
        q_word <= q_n;
      end else if (take) begin
        busy <= 1'b1;
        cnt  <= idx + 1'b1;
      end
    end
  end

  assert_valid_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_err_not_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(out_valid && frame_err));
  assert_err_needs_strobe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |-> $past(ser_strobe));
  assert_err_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    frame_err |=> !frame_err);
  assert_sym_q_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cfg_fmt) != FMT_IQ) |-> (q_word == '0));
  assert_byte_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cfg_fmt) == FMT_SYM8) |-> ((i_word & ~MASK_BYTE) == '0));
  assert_narrow_width_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && $past(cfg_fmt) == FMT_SYM2) |-> ((i_word & ~MASK_NARROW) == '0));

endmodule

// File: tb/sim_iq_deser.sv
module sim_iq_deser;
  localparam int CLK_NS = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_level_strobe = 1'b0, cfg_q_first = 1'b0, cfg_lsb_first = 1'b0;
  logic [1:0] cfg_fmt = 2'd0;
  logic ser_strobe = 1'b0, ser_data = 1'b0;
  logic ref_clk_out, out_valid, frame_err;
  logic [15:0] i_word, q_word;
  int checks = 0, fails = 0;

  always #(CLK_NS/2) clk = ~clk;

  iq_deser u0 (
    .clk(clk), .rst_n(rst_n), .cfg_level_strobe(cfg_level_strobe),
    .cfg_q_first(cfg_q_first), .cfg_lsb_first(cfg_lsb_first), .cfg_fmt(cfg_fmt),
    .ser_strobe(ser_strobe), .ser_data(ser_data), .ref_clk_out(ref_clk_out),
    .i_word(i_word), .q_word(q_word), .out_valid(out_valid), .frame_err(frame_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic int frame_len(input logic [1:0] f);
    return (f == 2'd0) ? 32 : (f == 2'd3) ? 16 : 8;
  endfunction

  function automatic logic frame_bit(input logic [1:0] f, input logic qf, input logic lsb,
                                     input logic [15:0] iv, input logic [15:0] qv,
                                     input logic [5:0] dm, input int k);
    logic [15:0] w;
    int jj, span;
    if (f == 2'd0) begin
      w = (k < 16) ? (qf ? qv : iv) : (qf ? iv : qv);
      jj = k % 16; span = 16;
    end else if (f == 2'd3) begin
      w = iv; jj = k; span = 16;
    end else if (f == 2'd2) begin
      w = {8'h00, iv[7:0]}; jj = k; span = 8;
    end else begin
      w = {8'h00, dm, iv[1:0]}; jj = k; span = 8;
    end
    return w[lsb ? jj : span - 1 - jj];
  endfunction

  task automatic drive_bit(input logic s, input logic d);
    ser_strobe = s;
    ser_data   = d;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_cfg(input logic [1:0] f, input logic lv, input logic qf, input logic lsb);
    cfg_fmt = f; cfg_level_strobe = lv; cfg_q_first = qf; cfg_lsb_first = lsb;
  endtask

  task automatic send_frame(input logic [15:0] iv, input logic [15:0] qv,
                            input logic [5:0] dm, input logic exp_err0);
    int len;
    logic early_v, early_e, err0;
    logic [15:0] ei, eq;
    string dtag, stag;
    len = frame_len(cfg_fmt);
    early_v = 1'b0; early_e = 1'b0; err0 = 1'b0;
    for (int k = 0; k < len; k++) begin
      drive_bit(cfg_level_strobe ? (k < len/2) : (k == 0),
                frame_bit(cfg_fmt, cfg_q_first, cfg_lsb_first, iv, qv, dm, k));
      if (k == 0) err0 = frame_err;
      else if (k < len - 1) early_e |= frame_err;
      if (k < len - 1) early_v |= out_valid;
    end
    case (cfg_fmt)
      2'd0: begin ei = iv; eq = qv; dtag = "R4/R5"; end
      2'd3: begin ei = iv; eq = '0; dtag = "R6/R5"; end
      2'd2: begin ei = {8'h00, iv[7:0]}; eq = '0; dtag = "R7/R5"; end
      default: begin ei = {14'h0, iv[1:0]}; eq = '0; dtag = "R8/R5"; end
    endcase
    stag = cfg_level_strobe ? "R3/R9" : "R2/R9";
    chk(out_valid === 1'b1, stag, "valid after final bit", 32'(out_valid), 32'd1);
    chk(early_v === 1'b0, "R9", "no valid before final bit", 32'(early_v), 32'd0);
    chk(early_e === 1'b0 && frame_err === 1'b0, "R10", "no error inside frame",
        32'(early_e | frame_err), 32'd0);
    chk(err0 === exp_err0, "R10", "error on frame start", 32'(err0), 32'(exp_err0));
    chk(i_word === ei, dtag, "i_word", 32'(i_word), 32'(ei));
    chk(q_word === eq, dtag, "q_word", 32'(q_word), 32'(eq));
  endtask

  initial begin
    #(CLK_NS * 200000);
    checks++;
    fails++;
    $display("FAIL R9 watchdog actual=hung expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [15:0] iv, qv;
    logic [5:0] dm;
    logic [4:0] cv;
    logic seen_v, seen_e;
    int nval;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0 && frame_err === 1'b0, "R1", "flags in reset",
        32'({out_valid, frame_err}), 32'd0);
    chk(i_word === 16'h0 && q_word === 16'h0, "R1", "words in reset",
        {i_word, q_word}, 32'd0);
    rst_n = 1'b1;
    repeat (2) drive_bit(1'b0, 1'b1);
    chk(out_valid === 1'b0 && i_word === 16'h0 && q_word === 16'h0, "R1",
        "state after reset", {i_word, q_word}, 32'd0);

    // R13
    chk(ref_clk_out === 1'b0, "R13", "reference clock low", 32'(ref_clk_out), 32'd0);
    @(posedge clk);
    #1;
    chk(ref_clk_out === 1'b1, "R13", "reference clock high", 32'(ref_clk_out), 32'd1);
    @(negedge clk);

    for (int c = 0; c < 32; c++) begin
      cv = 5'(c);
      set_cfg(cv[4:3], cv[2], cv[1], cv[0]);
      for (int fr = 0; fr < 4; fr++) begin
        iv = 16'(c * 7919 + fr * 40503 + 123);
        qv = 16'(iv * 3 + 16'h1234);
        dm = 6'(iv >> 5) | 6'h20;
        send_frame(iv, qv, dm, 1'b0);
        if (fr % 2 == 1) repeat (3) drive_bit(1'b0, 1'b1);
      end
    end

    // R12: idle bits ignored
    set_cfg(2'd0, 1'b0, 1'b0, 1'b0);
    send_frame(16'h5A3C, 16'hC3A5, 6'h0, 1'b0);
    seen_v = 1'b0; seen_e = 1'b0;
    for (int k = 0; k < 20; k++) begin
      drive_bit(1'b0, 1'b1);
      seen_v |= out_valid; seen_e |= frame_err;
    end
    chk(seen_v === 1'b0 && seen_e === 1'b0, "R12", "no activity on idle bits",
        32'({seen_v, seen_e}), 32'd0);
    chk(i_word === 16'h5A3C && q_word === 16'hC3A5, "R12", "words held over idle bits",
        {i_word, q_word}, {16'h5A3C, 16'hC3A5});

    // R3: level held high through and past one frame
    set_cfg(2'd0, 1'b1, 1'b0, 1'b1);
    drive_bit(1'b0, 1'b0);
    nval = 0; seen_e = 1'b0;
    for (int k = 0; k < 38; k++) begin
      drive_bit(1'b1, (k < 32) ? frame_bit(2'd0, 1'b0, 1'b1, 16'h1357, 16'h2468, 6'h0, k) : 1'b1);
      if (out_valid) nval++;
      seen_e |= frame_err;
      if (k == 31) begin
        chk(out_valid === 1'b1, "R3", "valid at frame end with strobe held", 32'(out_valid), 32'd1);
        chk(i_word === 16'h1357 && q_word === 16'h2468, "R3", "data with strobe held",
            {i_word, q_word}, {16'h1357, 16'h2468});
      end
    end
    chk(nval == 1 && seen_e === 1'b0, "R3", "held strobe starts one frame only",
        32'({nval[15:0], 15'h0, seen_e}), 32'h0001_0000);
    drive_bit(1'b0, 1'b0);

    // R10: pulse restart mid-frame, partial dropped
    set_cfg(2'd0, 1'b0, 1'b1, 1'b0);
    seen_v = 1'b0;
    drive_bit(1'b1, 1'b0);
    for (int k = 0; k < 9; k++) begin
      drive_bit(1'b0, 1'b1);
      seen_v |= out_valid;
    end
    chk(seen_v === 1'b0, "R10", "no valid for partial frame", 32'(seen_v), 32'd0);
    send_frame(16'hBEEF, 16'h0FF1, 6'h0, 1'b1);

    // R11: pulse strobe high on second cycle
    set_cfg(2'd2, 1'b0, 1'b0, 1'b0);
    drive_bit(1'b1, 1'b1);
    send_frame(16'h00A7, 16'h0, 6'h0, 1'b1);
    set_cfg(2'd1, 1'b0, 1'b0, 1'b1);
    drive_bit(1'b1, 1'b0);
    send_frame(16'h0002, 16'h0, 6'h3F, 1'b1);

    // R10: level rising again before frame completes
    set_cfg(2'd3, 1'b1, 1'b0, 1'b0);
    repeat (3) drive_bit(1'b1, 1'b1);
    drive_bit(1'b0, 1'b0);
    send_frame(16'h9C4E, 16'h0, 6'h0, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule